// File: doc/BRIEF.md
# Fixed-Point Instruction Decoder

This block turns one 32-bit fixed-point instruction word into a flat decoded record that execution logic can act on directly. The record names the target function unit, an internal operation code, the instruction form, where operands 1 and 2 come from, where the result goes, how the record (condition) flag is chosen and what carry-in the operation uses. It also carries the extracted register numbers, each with a valid flag, the extended 64-bit immediate, the resolved record-enable and the resolved overflow-enable.

Decoding is a two-level cascade. The 6-bit primary opcode (bits 31:26) is matched first. Only when it selects the register-register group (primary 31) are the extended opcode slices examined: the 9-bit XO-form slice (bits 9:1, with the OE bit at bit 10 ignored for matching) and then the 10-bit X-form slice (bits 10:1). A separate mode input, driven from a machine-state register, opens one additional primary opcode for a GPU instruction group; with the mode low that opcode is illegal. The block is purely combinational.

Top module: `fx_insn_decoder`

## Requirements
- R1: Any primary opcode outside the covered set decodes as illegal: illegal=1, fnUnit=0 (none), intOp=0 (illegal), all selects 0, every valid flag, immOk, recordEn and ovEnable 0, and register numbers and imm read 0. An all-zero word is illegal.
- R2: Under primary 31, an extended opcode that matches neither the XO slice nor the X slice decodes as illegal exactly as in R1.
- R3: Primary 31 with bits 9:1 = 266 decodes as add: fnUnit=1 (ALU), intOp=1, form=3 (XO), in1Sel=1 (RA, bits 20:16 on regA), in2Sel=1 (RB, bits 15:11 on regB), outSel=1 (RT, bits 25:21 on regOut), rcSel=2 (taken from bit 0, which drives recordEn), cryIn=0 (zero). Register numbers read 0 whenever their valid flag is clear.
- R4: For the XO-form rows, ovEnable equals bit 10 and bit 10 does not change the matched operation; all other rows give ovEnable=0.
- R5: XO rows: subf (40) intOp=2 cryIn=1 (one); neg (104) intOp=3, in2Sel=0, regBOk=0, cryIn=1; adde (138) intOp=1 cryIn=2 (carry flag); addze (202) intOp=1, in2Sel=0, regBOk=0, cryIn=2. All use the ALU, RA, RT and rcSel=2.
- R6: addi (primary 14) and addis (15): ALU, intOp=1, form=1 (D), in1Sel=2 (RA or literal zero), outSel=1, rcSel=0, cryIn=0; addi uses in2Sel=2 with bits 15:0 sign-extended to 64 bits, addis uses in2Sel=3 with bits 15:0 shifted left 16 then sign-extended; an RA field of 0 clears regAOk.
- R7: cmp (primary 31, X value 0) and cmpi (primary 11) give ALU, intOp=4, outSel=0, regOutOk=0, rcSel=0; cmp takes RA and RB (form 2), cmpi takes RA and the sign-extended immediate (form 1, in2Sel=2).
- R8: X-form logical ops give fnUnit=2 (logic), form 2, in1Sel=3 (RS, bits 25:21 on regA), in2Sel=1, outSel=2 (RA, bits 20:16 on regOut), rcSel=2, cryIn=0, with X values and intOp: and 28/5, or 444/6, xor 316/7, nand 476/8, eqv 284/9, andc 60/10, orc 412/11.
- R9: Logical immediates (form 1, logic unit, in1Sel=3, outSel=2) zero-extend: ori (24, intOp 6) and xori (26, intOp 7) use in2Sel=4; oris (25, intOp 6) and xoris (27, intOp 7) use in2Sel=5 (shifted left 16); these use rcSel=0. andi. (28, intOp 5, in2Sel=4) uses rcSel=1 so recordEn=1.
- R10: Primary 22 with gpuEn=1 gives fnUnit=3, intOp=12, form 2, RA, RB, RT, rcSel=2, cryIn=0; with gpuEn=0 it is illegal as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| gpuEn | input | 1 | Mode bit enabling the GPU group |
| illegal | output | 1 | Word not recognised |
| fnUnit | output | 2 | Target function unit |
| intOp | output | 4 | Internal operation code |
| form | output | 2 | Instruction form |
| in1Sel | output | 2 | Operand 1 source |
| in2Sel | output | 3 | Operand 2 source |
| outSel | output | 2 | Result destination |
| rcSel | output | 2 | Record flag policy |
| cryIn | output | 2 | Carry-in policy |
| regA | output | 5 | Operand 1 register number |
| regAOk | output | 1 | Operand 1 register is read |
| regB | output | 5 | Operand 2 register number |
| regBOk | output | 1 | Operand 2 register is read |
| regOut | output | 5 | Result register number |
| regOutOk | output | 1 | Result register is written |
| imm | output | 64 | Extended immediate |
| immOk | output | 1 | Immediate is operand 2 |
| recordEn | output | 1 | Resolved record flag |
| ovEnable | output | 1 | Resolved overflow enable |

## Verification
The two behaviours that meet in one word are the overflow bit and the record bit of an XO-form instruction, both drawn from low bits that also sit inside the extended opcode slice. A word with bit 10 and bit 0 both set is applied to add and compared against a record where the operation still reads as add while ovEnable and recordEn are both high. In the same way addi with an RA field of zero combines the immediate path with the literal-zero rule, and the record must show the immediate valid while regAOk is low.

// File: rtl/fx_dec_pkg.sv
package fx_dec_pkg;

  typedef enum logic [1:0] {FU_NONE = 2'd0, FU_ALU = 2'd1, FU_LOGIC = 2'd2, FU_GPU = 2'd3} fu_e;

  typedef enum logic [3:0] {
    OP_ILLEGAL = 4'd0, OP_ADD = 4'd1, OP_SUBF = 4'd2, OP_NEG = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR = 4'd6, OP_XOR = 4'd7,
    OP_NAND = 4'd8, OP_EQV = 4'd9, OP_ANDC = 4'd10, OP_ORC = 4'd11,
    OP_GPU = 4'd12
  } op_e;

  typedef enum logic [1:0] {FORM_NONE = 2'd0, FORM_D = 2'd1, FORM_X = 2'd2, FORM_XO = 2'd3} form_e;
  typedef enum logic [1:0] {IN1_NONE = 2'd0, IN1_RA = 2'd1, IN1_RA0 = 2'd2, IN1_RS = 2'd3} in1_e;
  typedef enum logic [2:0] {
    IN2_NONE = 3'd0, IN2_RB = 3'd1, IN2_SI = 3'd2, IN2_SIHI = 3'd3, IN2_UI = 3'd4, IN2_UIHI = 3'd5
  } in2_e;
  typedef enum logic [1:0] {OUT_NONE = 2'd0, OUT_RT = 2'd1, OUT_RA = 2'd2} out_e;
  typedef enum logic [1:0] {RC_NONE = 2'd0, RC_ONE = 2'd1, RC_BIT = 2'd2} rc_e;
  typedef enum logic [1:0] {CRY_ZERO = 2'd0, CRY_ONE = 2'd1, CRY_CA = 2'd2} cry_e;

  // Fields the datapath needs to shape register, immediate and flag outputs
  typedef struct packed {
    in1_e in1;
    in2_e in2;
    out_e out;
    rc_e  rc;
    logic oeUse;
  } dpStrobe_t;

  typedef struct packed {
    fu_e   fu;
    op_e   op;
    form_e form;
    cry_e  cry;
    logic  illegal;
  } decHdr_t;

  typedef struct packed {
    decHdr_t   hdr;
    dpStrobe_t stb;
  } decRow_t;

  function automatic decRow_t mkRow(fu_e fu, op_e op, form_e form, in1_e in1, in2_e in2,
                                    out_e out, rc_e rc, cry_e cry, logic oeUse);
    decRow_t r;
    r.hdr = '{fu: fu, op: op, form: form, cry: cry, illegal: 1'b0};
    r.stb = '{in1: in1, in2: in2, out: out, rc: rc, oeUse: oeUse};
    return r;
  endfunction

  function automatic decRow_t illegalRow();
    decRow_t r;
    r = mkRow(FU_NONE, OP_ILLEGAL, FORM_NONE, IN1_NONE, IN2_NONE, OUT_NONE, RC_NONE, CRY_ZERO, 1'b0);
    r.hdr.illegal = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/fx_dec_ctrl.sv
module fx_dec_ctrl
  import fx_dec_pkg::*;
#(
  parameter int PRIM_W      = 6,
  parameter int EXT_W       = 10,
  parameter int GPU_PRIMARY = 22
) (
  input  logic [PRIM_W-1:0] primOp,
  input  logic [EXT_W-1:0]  extOp,
  input  logic              gpuEn,
  output decHdr_t           hdr,
  output dpStrobe_t         strobe
);
  localparam int XO_W = EXT_W - 1;

  decRow_t xoRow, xRow, topRow;
  logic    xoHit, xHit;

  // Level 2a: XO slice, overflow bit excluded from the match
  always_comb begin
    xoHit = 1'b1;
    unique case (extOp[XO_W-1:0])
      9'd266:  xoRow = mkRow(FU_ALU, OP_ADD,  FORM_XO, IN1_RA, IN2_RB,   OUT_RT, RC_BIT, CRY_ZERO, 1'b1);
      9'd40:   xoRow = mkRow(FU_ALU, OP_SUBF, FORM_XO, IN1_RA, IN2_RB,   OUT_RT, RC_BIT, CRY_ONE,  1'b1);
      9'd104:  xoRow = mkRow(FU_ALU, OP_NEG,  FORM_XO, IN1_RA, IN2_NONE, OUT_RT, RC_BIT, CRY_ONE,  1'b1);
      9'd138:  xoRow = mkRow(FU_ALU, OP_ADD,  FORM_XO, IN1_RA, IN2_RB,   OUT_RT, RC_BIT, CRY_CA,   1'b1);
      9'd202:  xoRow = mkRow(FU_ALU, OP_ADD,  FORM_XO, IN1_RA, IN2_NONE, OUT_RT, RC_BIT, CRY_CA,   1'b1);
      default: begin xoHit = 1'b0; xoRow = illegalRow(); end
    endcase
  end

  // Level 2b: full X slice
  always_comb begin
    xHit = 1'b1;
    unique case (extOp)
      10'd0:   xRow = mkRow(FU_ALU,   OP_CMP,  FORM_X, IN1_RA, IN2_RB, OUT_NONE, RC_NONE, CRY_ZERO, 1'b0);
      10'd28:  xRow = mkRow(FU_LOGIC, OP_AND,  FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd444: xRow = mkRow(FU_LOGIC, OP_OR,   FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd316: xRow = mkRow(FU_LOGIC, OP_XOR,  FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd476: xRow = mkRow(FU_LOGIC, OP_NAND, FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd284: xRow = mkRow(FU_LOGIC, OP_EQV,  FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd60:  xRow = mkRow(FU_LOGIC, OP_ANDC, FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      10'd412: xRow = mkRow(FU_LOGIC, OP_ORC,  FORM_X, IN1_RS, IN2_RB, OUT_RA,   RC_BIT,  CRY_ZERO, 1'b0);
      default: begin xHit = 1'b0; xRow = illegalRow(); end
    endcase
  end

  // Level 1: primary opcode, descending into level 2 only for group 31
  always_comb begin
    topRow = illegalRow();
    if (primOp == PRIM_W'(GPU_PRIMARY)) begin
      if (gpuEn)
        topRow = mkRow(FU_GPU, OP_GPU, FORM_X, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO, 1'b0);
    end else begin
      unique case (primOp)
        6'd14: topRow = mkRow(FU_ALU,   OP_ADD, FORM_D, IN1_RA0, IN2_SI,   OUT_RT,   RC_NONE, CRY_ZERO, 1'b0);
        6'd15: topRow = mkRow(FU_ALU,   OP_ADD, FORM_D, IN1_RA0, IN2_SIHI, OUT_RT,   RC_NONE, CRY_ZERO, 1'b0);
        6'd11: topRow = mkRow(FU_ALU,   OP_CMP, FORM_D, IN1_RA,  IN2_SI,   OUT_NONE, RC_NONE, CRY_ZERO, 1'b0);
        6'd28: topRow = mkRow(FU_LOGIC, OP_AND, FORM_D, IN1_RS,  IN2_UI,   OUT_RA,   RC_ONE,  CRY_ZERO, 1'b0);
        6'd24: topRow = mkRow(FU_LOGIC, OP_OR,  FORM_D, IN1_RS,  IN2_UI,   OUT_RA,   RC_NONE, CRY_ZERO, 1'b0);
        6'd25: topRow = mkRow(FU_LOGIC, OP_OR,  FORM_D, IN1_RS,  IN2_UIHI, OUT_RA,   RC_NONE, CRY_ZERO, 1'b0);
        6'd26: topRow = mkRow(FU_LOGIC, OP_XOR, FORM_D, IN1_RS,  IN2_UI,   OUT_RA,   RC_NONE, CRY_ZERO, 1'b0);
        6'd27: topRow = mkRow(FU_LOGIC, OP_XOR, FORM_D, IN1_RS,  IN2_UIHI, OUT_RA,   RC_NONE, CRY_ZERO, 1'b0);
        6'd31: topRow = xoHit ? xoRow : (xHit ? xRow : illegalRow());
        default: topRow = illegalRow();
      endcase
    end
  end

  assign hdr    = topRow.hdr;
  assign strobe = topRow.stb;
endmodule

// File: rtl/fx_dec_dpath.sv
module fx_dec_dpath
  import fx_dec_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int IMM_W = 16,
  parameter int XLEN  = 64
) (
  input  dpStrobe_t        strobe,
  input  logic [REG_W-1:0] rtF,
  input  logic [REG_W-1:0] raF,
  input  logic [REG_W-1:0] rbF,
  input  logic [IMM_W-1:0] dF,
  input  logic             oeBit,
  input  logic             rcBit,
  output logic [REG_W-1:0] regA,
  output logic             regAOk,
  output logic [REG_W-1:0] regB,
  output logic             regBOk,
  output logic [REG_W-1:0] regOut,
  output logic             regOutOk,
  output logic [XLEN-1:0]  imm,
  output logic             immOk,
  output logic             recordEn,
  output logic             ovEnable
);
  localparam int LO_EXT = XLEN - IMM_W;
  localparam int HI_EXT = XLEN - 2 * IMM_W;

  logic [XLEN-1:0] sLo, sHi, uLo, uHi;
  assign sLo = {{LO_EXT{dF[IMM_W-1]}}, dF};
  assign sHi = {{HI_EXT{dF[IMM_W-1]}}, dF, {IMM_W{1'b0}}};
  assign uLo = {{LO_EXT{1'b0}}, dF};
  assign uHi = {{HI_EXT{1'b0}}, dF, {IMM_W{1'b0}}};

  always_comb begin
    regA = '0; regAOk = 1'b0;
    unique case (strobe.in1)
      IN1_RA:  begin regA = raF; regAOk = 1'b1; end
      IN1_RA0: begin regAOk = (raF != '0); regA = raF; end
      IN1_RS:  begin regA = rtF; regAOk = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    regB = '0; regBOk = 1'b0; imm = '0; immOk = 1'b0;
    unique case (strobe.in2)
      IN2_RB:   begin regB = rbF; regBOk = 1'b1; end
      IN2_SI:   begin imm = sLo; immOk = 1'b1; end
      IN2_SIHI: begin imm = sHi; immOk = 1'b1; end
      IN2_UI:   begin imm = uLo; immOk = 1'b1; end
      IN2_UIHI: begin imm = uHi; immOk = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    regOut = '0; regOutOk = 1'b0;
    unique case (strobe.out)
      OUT_RT:  begin regOut = rtF; regOutOk = 1'b1; end
      OUT_RA:  begin regOut = raF; regOutOk = 1'b1; end
      default: ;
    endcase
  end

  assign recordEn = (strobe.rc == RC_ONE) | ((strobe.rc == RC_BIT) & rcBit);
  assign ovEnable = strobe.oeUse & oeBit;
endmodule

// File: rtl/fx_insn_decoder.sv
module fx_insn_decoder
  import fx_dec_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int GPU_PRIMARY = 22
) (
  input  logic [31:0]     insn,
  input  logic            gpuEn,
  output logic            illegal,
  output logic [1:0]      fnUnit,
  output logic [3:0]      intOp,
  output logic [1:0]      form,
  output logic [1:0]      in1Sel,
  output logic [2:0]      in2Sel,
  output logic [1:0]      outSel,
  output logic [1:0]      rcSel,
  output logic [1:0]      cryIn,
  output logic [4:0]      regA,
  output logic            regAOk,
  output logic [4:0]      regB,
  output logic            regBOk,
  output logic [4:0]      regOut,
  output logic            regOutOk,
  output logic [XLEN-1:0] imm,
  output logic            immOk,
  output logic            recordEn,
  output logic            ovEnable
);
  decHdr_t   hdr;
  dpStrobe_t strobe;

  fx_dec_ctrl #(.PRIM_W(6), .EXT_W(10), .GPU_PRIMARY(GPU_PRIMARY)) u_ctrl (
    .primOp(insn[31:26]), .extOp(insn[10:1]), .gpuEn(gpuEn), .hdr(hdr), .strobe(strobe)
  );

  fx_dec_dpath #(.REG_W(5), .IMM_W(16), .XLEN(XLEN)) u_dpath (
    .strobe(strobe), .rtF(insn[25:21]), .raF(insn[20:16]), .rbF(insn[15:11]), .dF(insn[15:0]),
    .oeBit(insn[10]), .rcBit(insn[0]),
    .regA(regA), .regAOk(regAOk), .regB(regB), .regBOk(regBOk),
    .regOut(regOut), .regOutOk(regOutOk), .imm(imm), .immOk(immOk),
    .recordEn(recordEn), .ovEnable(ovEnable)
  );

  assign illegal = hdr.illegal;
  assign fnUnit  = hdr.fu;
  assign intOp   = hdr.op;
  assign form    = hdr.form;
  assign cryIn   = hdr.cry;
  assign in1Sel  = strobe.in1;
  assign in2Sel  = strobe.in2;
  assign outSel  = strobe.out;
  assign rcSel   = strobe.rc;
endmodule

// File: rtl/fx_insn_decoder_chk.sv
module fx_insn_decoder_chk #(
  parameter int XLEN        = 64,
  parameter int GPU_PRIMARY = 22
) (
  input logic [31:0]     insn,
  input logic            gpuEn,
  input logic            illegal,
  input logic [1:0]      fnUnit,
  input logic            regAOk,
  input logic            regBOk,
  input logic            regOutOk,
  input logic [XLEN-1:0] imm,
  input logic            immOk,
  input logic            recordEn,
  input logic            ovEnable
);
  logic known;
  assign known = !$isunknown({insn, gpuEn});

  always_comb begin
    if (known) begin
      // R1 / R2: an unrecognised word leaves nothing valid
      a_r1_illegal_clears: assert (!illegal || !(regAOk | regBOk | regOutOk | immOk | recordEn | ovEnable))
        else $error("illegal word left a valid flag set");
      // R3: operand 2 is either a register or the immediate, never both
      a_r3_op2_exclusive: assert (!(immOk && regBOk))
        else $error("operand 2 claims both register and immediate");
      // R6: literal-zero operand for addi/addis
      a_r6_ra_zero: assert (!((insn[31:26] == 6'd14 || insn[31:26] == 6'd15) && insn[20:16] == 5'd0) || !regAOk)
        else $error("RA=0 still marked as a register read");
      // R9: logical immediates carry no upper bits
      a_r9_logic_zext: assert (!(fnUnit == 2'd2 && immOk) || imm[XLEN-1:32] == '0)
        else $error("logical immediate not zero-extended");
      // R10: GPU group is closed with the mode bit low
      a_r10_gpu_gate: assert (gpuEn || insn[31:26] != 6'(GPU_PRIMARY) || illegal)
        else $error("GPU group decoded with mode bit low");
    end
  end
endmodule

bind fx_insn_decoder fx_insn_decoder_chk #(.XLEN(XLEN), .GPU_PRIMARY(GPU_PRIMARY)) u_chk (.*);

// File: tb/fx_insn_decoder_bench.sv
module fx_insn_decoder_bench;
  import fx_dec_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic illegal; logic [1:0] fu; logic [3:0] op; logic [1:0] form;
    logic [1:0] in1; logic [2:0] in2; logic [1:0] out; logic [1:0] rc; logic [1:0] cry;
    logic [4:0] ra; logic raOk; logic [4:0] rb; logic rbOk; logic [4:0] ro; logic roOk;
    logic [63:0] imm; logic immOk; logic rec; logic ov;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] insn = '0;
  logic gpuEn = 1'b0;

  logic illegal, regAOk, regBOk, regOutOk, immOk, recordEn, ovEnable;
  logic [1:0] fnUnit, form, in1Sel, outSel, rcSel, cryIn;
  logic [3:0] intOp;
  logic [2:0] in2Sel;
  logic [4:0] regA, regB, regOut;
  logic [63:0] imm;

  fx_insn_decoder u_fx_insn_decoder (
    .insn(insn), .gpuEn(gpuEn), .illegal(illegal), .fnUnit(fnUnit), .intOp(intOp), .form(form),
    .in1Sel(in1Sel), .in2Sel(in2Sel), .outSel(outSel), .rcSel(rcSel), .cryIn(cryIn),
    .regA(regA), .regAOk(regAOk), .regB(regB), .regBOk(regBOk), .regOut(regOut),
    .regOutOk(regOutOk), .imm(imm), .immOk(immOk), .recordEn(recordEn), .ovEnable(ovEnable)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  rec_t  expQ[$];
  string tagQ[$];
  bit    driveDone = 1'b0;

  function automatic rec_t ex(int fu, int op, int fm, int i1, int i2, int o, int rc, int cry,
                              int ra, bit raOk, int rb, bit rbOk, int ro, bit roOk,
                              logic [63:0] im, bit imOk, bit rec, bit ov);
    rec_t r;
    r.illegal = 1'b0; r.fu = 2'(fu); r.op = 4'(op); r.form = 2'(fm);
    r.in1 = 2'(i1); r.in2 = 3'(i2); r.out = 2'(o); r.rc = 2'(rc); r.cry = 2'(cry);
    r.ra = 5'(ra); r.raOk = raOk; r.rb = 5'(rb); r.rbOk = rbOk; r.ro = 5'(ro); r.roOk = roOk;
    r.imm = im; r.immOk = imOk; r.rec = rec; r.ov = ov;
    return r;
  endfunction

  function automatic rec_t illExp();
    rec_t r = '0;
    r.illegal = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] dw(int po, int rt, int ra, logic [15:0] d);
    return {6'(po), 5'(rt), 5'(ra), d};
  endfunction

  function automatic logic [31:0] xw(int po, int rt, int ra, int rb, int xo, bit rc);
    return {6'(po), 5'(rt), 5'(ra), 5'(rb), 10'(xo), rc};
  endfunction

  function automatic logic [31:0] xow(int rt, int ra, int rb, bit oe, int xo, bit rc);
    return {6'd31, 5'(rt), 5'(ra), 5'(rb), oe, 9'(xo), rc};
  endfunction

  task automatic send(logic [31:0] w, logic g, rec_t e, string tag);
    @(posedge clk);
    insn = w;
    gpuEn = g;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares the settled outputs half a period after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && expQ.size() > 0) begin
        rec_t e, a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = '{illegal, fnUnit, intOp, form, in1Sel, in2Sel, outSel, rcSel, cryIn,
              regA, regAOk, regB, regBOk, regOut, regOutOk, imm, immOk, recordEn, ovEnable};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!driveDone && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!driveDone) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1: all-zero word after reset
    send(32'h0, 1'b0, illExp(), "R1 zero word");
    // R3: add with and without record bit
    send(xow(3, 4, 5, 0, 266, 0), 0, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO,
         4, 1, 5, 1, 3, 1, 0, 0, 0, 0), "R3 add");
    send(xow(3, 4, 5, 0, 266, 1), 0, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO,
         4, 1, 5, 1, 3, 1, 0, 0, 1, 0), "R3 add.");
    // R4: overflow and record bit together
    send(xow(31, 30, 29, 1, 266, 1), 0, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO,
         30, 1, 29, 1, 31, 1, 0, 0, 1, 1), "R4 addo.");
    // R5: carry policies and single-operand rows
    send(xow(1, 2, 3, 1, 40, 0), 0, ex(FU_ALU, OP_SUBF, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ONE,
         2, 1, 3, 1, 1, 1, 0, 0, 0, 1), "R5 subfo");
    send(xow(6, 7, 9, 0, 104, 0), 0, ex(FU_ALU, OP_NEG, FORM_XO, IN1_RA, IN2_NONE, OUT_RT, RC_BIT, CRY_ONE,
         7, 1, 0, 0, 6, 1, 0, 0, 0, 0), "R5 neg");
    send(xow(8, 9, 10, 0, 138, 1), 0, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_CA,
         9, 1, 10, 1, 8, 1, 0, 0, 1, 0), "R5 adde.");
    send(xow(11, 12, 13, 0, 202, 0), 0, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_NONE, OUT_RT, RC_BIT, CRY_CA,
         12, 1, 0, 0, 11, 1, 0, 0, 0, 0), "R5 addze");
    // R6: arithmetic immediates
    send(dw(14, 7, 3, 16'hFFF0), 0, ex(FU_ALU, OP_ADD, FORM_D, IN1_RA0, IN2_SI, OUT_RT, RC_NONE, CRY_ZERO,
         3, 1, 0, 0, 7, 1, 64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 0), "R6 addi negative");
    send(dw(14, 7, 0, 16'h0005), 0, ex(FU_ALU, OP_ADD, FORM_D, IN1_RA0, IN2_SI, OUT_RT, RC_NONE, CRY_ZERO,
         0, 0, 0, 0, 7, 1, 64'h5, 1, 0, 0), "R6 addi RA zero");
    send(dw(15, 2, 9, 16'h8000), 0, ex(FU_ALU, OP_ADD, FORM_D, IN1_RA0, IN2_SIHI, OUT_RT, RC_NONE, CRY_ZERO,
         9, 1, 0, 0, 2, 1, 64'hFFFF_FFFF_8000_0000, 1, 0, 0), "R6 addis");
    send(dw(15, 2, 0, 16'h1234), 0, ex(FU_ALU, OP_ADD, FORM_D, IN1_RA0, IN2_SIHI, OUT_RT, RC_NONE, CRY_ZERO,
         0, 0, 0, 0, 2, 1, 64'h1234_0000, 1, 0, 0), "R6 addis RA zero");
    // R7: compares
    send(xw(31, 4, 5, 6, 0, 1), 0, ex(FU_ALU, OP_CMP, FORM_X, IN1_RA, IN2_RB, OUT_NONE, RC_NONE, CRY_ZERO,
         5, 1, 6, 1, 0, 0, 0, 0, 0, 0), "R7 cmp");
    send(dw(11, 0, 6, 16'h7FFF), 0, ex(FU_ALU, OP_CMP, FORM_D, IN1_RA, IN2_SI, OUT_NONE, RC_NONE, CRY_ZERO,
         6, 1, 0, 0, 0, 0, 64'h7FFF, 1, 0, 0), "R7 cmpi");
    // R8: register-register logical ops
    begin
      int xos[7] = '{28, 444, 316, 476, 284, 60, 412};
      for (int k = 0; k < 7; k++)
        send(xw(31, 10 + k, 20, 21, xos[k], k[0]), 0,
             ex(FU_LOGIC, OP_AND + k, FORM_X, IN1_RS, IN2_RB, OUT_RA, RC_BIT, CRY_ZERO,
                10 + k, 1, 21, 1, 20, 1, 0, 0, k[0], 0), "R8 logical reg");
    end
    // R9: logical immediates
    send(dw(28, 10, 11, 16'h8001), 0, ex(FU_LOGIC, OP_AND, FORM_D, IN1_RS, IN2_UI, OUT_RA, RC_ONE, CRY_ZERO,
         10, 1, 0, 0, 11, 1, 64'h8001, 1, 1, 0), "R9 andi.");
    send(dw(24, 1, 2, 16'hF00F), 0, ex(FU_LOGIC, OP_OR, FORM_D, IN1_RS, IN2_UI, OUT_RA, RC_NONE, CRY_ZERO,
         1, 1, 0, 0, 2, 1, 64'hF00F, 1, 0, 0), "R9 ori");
    send(dw(25, 1, 2, 16'hABCD), 0, ex(FU_LOGIC, OP_OR, FORM_D, IN1_RS, IN2_UIHI, OUT_RA, RC_NONE, CRY_ZERO,
         1, 1, 0, 0, 2, 1, 64'hABCD_0000, 1, 0, 0), "R9 oris");
    send(dw(26, 3, 4, 16'h9999), 0, ex(FU_LOGIC, OP_XOR, FORM_D, IN1_RS, IN2_UI, OUT_RA, RC_NONE, CRY_ZERO,
         3, 1, 0, 0, 4, 1, 64'h9999, 1, 0, 0), "R9 xori");
    send(dw(27, 3, 4, 16'hFFFF), 0, ex(FU_LOGIC, OP_XOR, FORM_D, IN1_RS, IN2_UIHI, OUT_RA, RC_NONE, CRY_ZERO,
         3, 1, 0, 0, 4, 1, 64'hFFFF_0000, 1, 0, 0), "R9 xoris");
    // R2: unmatched extended opcodes under group 31
    send(xw(31, 1, 2, 3, 1, 1), 0, illExp(), "R2 ext 1");
    send(xow(1, 2, 3, 1, 300, 1), 0, illExp(), "R2 ext 812");
    // R1: uncovered primary opcodes
    send(dw(1, 5, 5, 16'h1), 0, illExp(), "R1 primary 1");
    send(dw(63, 5, 5, 16'h1), 1, illExp(), "R1 primary 63");
    // R10: GPU gate
    send(xw(22, 1, 2, 3, 5, 1), 0, illExp(), "R10 gpu off");
    send(xw(22, 1, 2, 3, 5, 1), 1, ex(FU_GPU, OP_GPU, FORM_X, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO,
         2, 1, 3, 1, 1, 1, 0, 0, 1, 0), "R10 gpu on");
    // R10: mode bit has no effect on covered rows
    send(xow(3, 4, 5, 0, 266, 0), 1, ex(FU_ALU, OP_ADD, FORM_XO, IN1_RA, IN2_RB, OUT_RT, RC_BIT, CRY_ZERO,
         4, 1, 5, 1, 3, 1, 0, 0, 0, 0), "R10 add with mode on");
    repeat (3) @(posedge clk);
    driveDone = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule